// File: doc/BRIEF.md
# Most-Valuable-Victim Selection Arbiter

This block chooses the next capture target for a hardware move generator. Every board square supplies a flag saying that some pseudo-legal move lands on it, a 3-bit code for the piece standing there, and a hint bit marking a killer move. A comparator tree reduces all eligible squares to one winner. The winner is the square holding the most valuable piece. The killer hint breaks ties between equal values, and the lowest square index settles any tie that is left. The chosen square index goes to a separate stage that looks for aggressors.

Squares that have already been examined are masked. Each square keeps one mask bit per search ply in a small per-square memory. Deeper plies therefore never disturb the masks of shallower ones, and a return to an earlier ply finds its masks as they were left. A start pulse selects the active ply. A next pulse retires the current winner. A clear pulse wipes one ply's masks for every square in a single cycle. When no eligible square is left, the block reports that the ply is exhausted.

Top module: `victim_arbiter`

## Requirements
- R1: While reset is held, and in the cycles just after it, `sel_valid` and `exhausted` are 0.
- R2: A square is eligible only when its `found` bit is 1 and its piece code (bits [3k+2:3k] of `piece_val` for square k) is 1 to 5 (pawn=1, knight=2, bishop=3, rook=4, queen=5). Codes 0 (empty), 6 (king) and 7 are never selected.
- R3: Among the eligible, unmasked squares, the one with the highest piece code is selected. Outputs are registered and reflect the inputs of the previous clock cycle.
- R4: Among squares with equal piece codes, a square whose `killer` bit is 1 beats one whose bit is 0.
- R5: Among squares with equal code and equal killer bit, the lowest square index wins.
- R6: A `next` pulse while `sel_valid` is 1 masks the selected square for the active ply. The following selection, one cycle later, excludes that square. A `next` pulse while `sel_valid` is 0 has no effect.
- R7: Once started, the block holds `exhausted`=1 and `sel_valid`=0 for every cycle in which no eligible, unmasked square exists. The two outputs are never both 1.
- R8: A `start` pulse makes `ply_idx` the active ply, and the selection in the next cycle already uses that ply's masks. Masks set in one ply do not affect another ply, and they survive changes to other plies.
- R9: A `clr_ply` pulse zeroes the masks of ply `ply_idx` for all squares in that cycle. If that ply is the one in use, previously masked squares can be selected in the very next cycle.
- R10: `next` is ignored in any cycle where `start` or `clr_ply` is 1.
- R11: Before the first `start` after reset, the outputs stay 0 whatever the square inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Make `ply_idx` the active ply and begin selecting |
| next | input | 1 | Retire the current selection in the active ply |
| clr_ply | input | 1 | Clear all masks of ply `ply_idx` |
| ply_idx | input | PLY_W | Ply operand for `start` and `clr_ply` |
| found | input | NSQ | Per-square pseudo-legal target flag |
| piece_val | input | NSQ*3 | Per-square piece code, square k in bits [3k+2:3k] |
| killer | input | NSQ | Per-square killer-move hint |
| sel_valid | output | 1 | `sel_sq` holds a valid victim |
| sel_sq | output | IDX_W | Index of the selected square |
| exhausted | output | 1 | Active ply has no remaining victim |

## Verification
A corrupted mask bit shows up at the ports on the cycle after its ply is next used. A wrongly set bit makes a square vanish early: a lower-valued victim, or `exhausted`, appears where a better square was due. A lost set makes the same square come back after `next`. A wrong comparison in the tree gives the wrong `sel_sq` one cycle after the inputs change. A bad active-ply register only shows once plies are revisited, so the stimulus moves among a few plies with frequent starts and clears, and every cycle is compared against an independent per-ply model.

// File: rtl/victim_pkg.sv
package victim_pkg;
  localparam int VAL_W = 3;
  localparam int KEY_W = VAL_W + 1;

  localparam logic [VAL_W-1:0] PC_EMPTY = 3'd0;
  localparam logic [VAL_W-1:0] PC_KING  = 3'd6;

  // a piece that can be captured: pawn..queen
  function automatic logic is_victim(input logic [VAL_W-1:0] code);
    return (code != PC_EMPTY) && (code < PC_KING);
  endfunction

  // ranking key: piece value first, killer hint as tie breaker
  function automatic logic [KEY_W-1:0] mk_key(input logic [VAL_W-1:0] code,
                                              input logic hint);
    return {code, hint};
  endfunction
endpackage

// File: rtl/victim_rst_sync.sv
module victim_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= 2'b00;
    else           sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_out = sync_q[1];
endmodule

// File: rtl/victim_mask_cell.sv
module victim_mask_cell #(
  parameter  int NPLY  = 32,
  localparam int PLY_W = $clog2(NPLY)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_en,
  input  logic             clr_en,
  input  logic [PLY_W-1:0] wr_ply,
  input  logic [PLY_W-1:0] rd_ply,
  output logic             rd_bit
);
  logic [NPLY-1:0] mem_q;
  logic [NPLY-1:0] mem_d;
  logic            mem_en;

  always_comb begin
    mem_d  = mem_q;
    mem_en = set_en | clr_en;
    if (clr_en)      mem_d[wr_ply] = 1'b0;
    else if (set_en) mem_d[wr_ply] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      mem_q <= '0;
    else if (mem_en) mem_q <= mem_d;
  end

  assign rd_bit = mem_q[rd_ply];

  p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    clr_en |=> !mem_q[$past(wr_ply)]);

  p_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (set_en && !clr_en) |=> mem_q[$past(wr_ply)]);
endmodule

// File: rtl/victim_tree.sv
module victim_tree #(
  parameter  int NSQ   = 64,
  localparam int IDX_W = $clog2(NSQ),
  localparam int KW    = victim_pkg::KEY_W,
  localparam int NODES = 2 * NSQ - 1
) (
  input  logic [NSQ-1:0]    leaf_vld,
  input  logic [NSQ*KW-1:0] leaf_key,
  output logic              win_vld,
  output logic [IDX_W-1:0]  win_idx,
  output logic [KW-1:0]     win_key
);
  // heap layout: node i has children 2i+1 and 2i+2, leaves at NSQ-1+k
  logic             node_vld [NODES];
  logic [KW-1:0]    node_key [NODES];
  logic [IDX_W-1:0] node_idx [NODES];

  if ((1 << IDX_W) != NSQ) begin : g_bad_size
    initial $error("victim_tree needs a power-of-two square count");
  end

  for (genvar k = 0; k < NSQ; k++) begin : g_leaf
    assign node_vld[NSQ-1+k] = leaf_vld[k];
    assign node_key[NSQ-1+k] = leaf_key[k*KW +: KW];
    assign node_idx[NSQ-1+k] = IDX_W'(k);
  end

  for (genvar i = 0; i < NSQ - 1; i++) begin : g_node
    logic take_r;
    // right (higher indices) wins only on a strictly larger key
    assign take_r = node_vld[2*i+2] &&
                    (!node_vld[2*i+1] || (node_key[2*i+2] > node_key[2*i+1]));
    assign node_vld[i] = node_vld[2*i+1] | node_vld[2*i+2];
    assign node_key[i] = take_r ? node_key[2*i+2] : node_key[2*i+1];
    assign node_idx[i] = take_r ? node_idx[2*i+2] : node_idx[2*i+1];
  end

  assign win_vld = node_vld[0];
  assign win_key = node_key[0];
  assign win_idx = node_idx[0];
endmodule

// File: rtl/victim_arbiter.sv
module victim_arbiter #(
  parameter  int NSQ   = 64,
  parameter  int NPLY  = 32,
  localparam int IDX_W = $clog2(NSQ),
  localparam int PLY_W = $clog2(NPLY),
  localparam int VW    = victim_pkg::VAL_W,
  localparam int KW    = victim_pkg::KEY_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              next,
  input  logic              clr_ply,
  input  logic [PLY_W-1:0]  ply_idx,
  input  logic [NSQ-1:0]    found,
  input  logic [NSQ*VW-1:0] piece_val,
  input  logic [NSQ-1:0]    killer,
  output logic              sel_valid,
  output logic [IDX_W-1:0]  sel_sq,
  output logic              exhausted
);
  import victim_pkg::*;

  logic rst_q;

  victim_rst_sync u_rst (.clk(clk), .rst_n_in(rst_n), .rst_n_out(rst_q));

  // state
  logic             active_q,  active_d;
  logic [PLY_W-1:0] act_ply_q, act_ply_d;
  logic             valid_q,   valid_d;
  logic [IDX_W-1:0] sq_q,      sq_d;
  logic             exh_q,     exh_d;

  // command decode
  logic             next_ok;
  logic             clr_hit;
  logic [PLY_W-1:0] eff_ply;
  logic [PLY_W-1:0] wr_ply;

  assign eff_ply = start ? ply_idx : act_ply_q;
  assign next_ok = next && valid_q && !start && !clr_ply;
  assign clr_hit = clr_ply && (ply_idx == eff_ply);
  assign wr_ply  = clr_ply ? ply_idx : act_ply_q;

  logic [NSQ-1:0]    mask_bit;
  logic [NSQ-1:0]    mask_eff;
  logic [NSQ-1:0]    set_hit;
  logic [NSQ-1:0]    leaf_vld;
  logic [NSQ*KW-1:0] leaf_key;

  for (genvar k = 0; k < NSQ; k++) begin : g_sq
    victim_mask_cell #(.NPLY(NPLY)) u_cell (
      .clk    (clk),
      .rst_n  (rst_q),
      .set_en (set_hit[k]),
      .clr_en (clr_ply),
      .wr_ply (wr_ply),
      .rd_ply (eff_ply),
      .rd_bit (mask_bit[k])
    );
    assign set_hit[k]  = next_ok && (sq_q == IDX_W'(k));
    // bypass this cycle's clear and set so the result lands one cycle later
    assign mask_eff[k] = (mask_bit[k] & ~clr_hit) | set_hit[k];
    assign leaf_vld[k] = found[k] & is_victim(piece_val[k*VW +: VW]) & ~mask_eff[k];
    assign leaf_key[k*KW +: KW] = mk_key(piece_val[k*VW +: VW], killer[k]);
  end

  logic             win_vld;
  logic [IDX_W-1:0] win_idx;
  logic [KW-1:0]    win_key;

  victim_tree #(.NSQ(NSQ)) u_tree (
    .leaf_vld (leaf_vld),
    .leaf_key (leaf_key),
    .win_vld  (win_vld),
    .win_idx  (win_idx),
    .win_key  (win_key)
  );

  always_comb begin
    active_d  = active_q | start;
    act_ply_d = start ? ply_idx : act_ply_q;
    valid_d   = active_d & win_vld;
    exh_d     = active_d & ~win_vld;
    sq_d      = win_vld ? win_idx : sq_q;
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      active_q  <= 1'b0;
      act_ply_q <= '0;
      valid_q   <= 1'b0;
      sq_q      <= '0;
      exh_q     <= 1'b0;
    end else begin
      active_q  <= active_d;
      act_ply_q <= act_ply_d;
      valid_q   <= valid_d;
      sq_q      <= sq_d;
      exh_q     <= exh_d;
    end
  end

  assign sel_valid = valid_q;
  assign sel_sq    = sq_q;
  assign exhausted = exh_q;

  // assertions
  p_excl_r7: assert property (@(posedge clk) disable iff (!rst_q)
    !(sel_valid && exhausted));

  p_idle_r11: assert property (@(posedge clk) disable iff (!rst_q)
    !active_q |-> (!sel_valid && !exhausted));

  p_no_repeat_r6: assert property (@(posedge clk) disable iff (!rst_q)
    next_ok |=> !(sel_valid && (sel_sq == $past(sel_sq))));

  p_ply_held_r8: assert property (@(posedge clk) disable iff (!rst_q)
    !start |=> (act_ply_q == $past(act_ply_q)));

  always @(posedge clk) begin
    if (rst_q) begin
      for (int k = 0; k < NSQ; k++) begin
        if (leaf_vld[k]) begin
          p_tree_max_r3: assert (win_vld && (win_key >= leaf_key[k*KW +: KW]));
        end
      end
    end
  end
endmodule

// File: tb/sim_victim_arbiter.sv
`timescale 1ns/1ps
module sim_victim_arbiter;
  localparam int NSQ   = 64;
  localparam int NPLY  = 32;
  localparam int IDX_W = $clog2(NSQ);
  localparam int PLY_W = $clog2(NPLY);

  logic              clk = 1'b0;
  logic              rst_n;
  logic              start, next, clr_ply;
  logic [PLY_W-1:0]  ply_idx;
  logic [NSQ-1:0]    found;
  logic [NSQ*3-1:0]  piece_val;
  logic [NSQ-1:0]    killer;
  logic              sel_valid;
  logic [IDX_W-1:0]  sel_sq;
  logic              exhausted;

  always #10 clk = ~clk;

  victim_arbiter #(.NSQ(NSQ), .NPLY(NPLY)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .next(next), .clr_ply(clr_ply),
    .ply_idx(ply_idx), .found(found), .piece_val(piece_val), .killer(killer),
    .sel_valid(sel_valid), .sel_sq(sel_sq), .exhausted(exhausted)
  );

  int  checks = 0;
  int  fails  = 0;
  bit  done   = 1'b0;

  // reference model state
  bit [NSQ-1:0]     m_mask [NPLY];
  bit               m_active;
  bit [PLY_W-1:0]   m_ply;
  bit               e_valid;
  bit [IDX_W-1:0]   e_sq;
  bit               e_exh;

  function automatic bit victim_code(input bit [2:0] c);
    return (c >= 3'd1) && (c <= 3'd5);
  endfunction

  task automatic model_cycle();
    bit [PLY_W-1:0] eff;
    bit [NSQ-1:0]   meff;
    bit             nok, any;
    bit [3:0]       bkey, key;
    bit [IDX_W-1:0] bsq;
    eff  = start ? ply_idx : m_ply;
    nok  = next && e_valid && !start && !clr_ply;
    meff = (clr_ply && ply_idx == eff) ? '0 : m_mask[eff];
    if (nok) meff[e_sq] = 1'b1;
    any = 1'b0; bkey = '0; bsq = '0;
    for (int k = 0; k < NSQ; k++) begin
      if (found[k] && victim_code(piece_val[k*3 +: 3]) && !meff[k]) begin
        key = {piece_val[k*3 +: 3], killer[k]};
        if (!any || key > bkey) begin
          any = 1'b1; bkey = key; bsq = IDX_W'(k);
        end
      end
    end
    if (clr_ply) m_mask[ply_idx] = '0;
    if (nok) m_mask[m_ply][e_sq] = 1'b1;
    if (start) m_ply = ply_idx;
    m_active = m_active | start;
    e_valid  = m_active && any;
    e_exh    = m_active && !any;
    if (any) e_sq = bsq;
  endtask

  task automatic compare(input string tag);
    checks++;
    if (sel_valid !== e_valid || exhausted !== e_exh ||
        (e_valid && sel_sq !== e_sq)) begin
      fails++;
      $display("FAIL %s: actual valid=%0b sq=%0d exh=%0b expected valid=%0b sq=%0d exh=%0b",
               tag, sel_valid, sel_sq, exhausted, e_valid, e_sq, e_exh);
    end
  endtask

  // inputs already driven at a falling edge; run one cycle and check
  task automatic step(input string tag);
    model_cycle();
    @(posedge clk);
    @(negedge clk);
    compare(tag);
    start = 1'b0; next = 1'b0; clr_ply = 1'b0;
  endtask

  task automatic put(input int sq, input int code, input bit hint);
    found[sq] = 1'b1;
    piece_val[sq*3 +: 3] = 3'(code);
    killer[sq] = hint;
  endtask

  task automatic wipe();
    found = '0; piece_val = '0; killer = '0;
  endtask

  initial begin
    void'($urandom(32'd4242));
    for (int p = 0; p < NPLY; p++) m_mask[p] = '0;
    m_active = 0; m_ply = '0; e_valid = 0; e_sq = '0; e_exh = 0;
    rst_n = 1'b0; start = 0; next = 0; clr_ply = 0; ply_idx = '0;
    found = '1; piece_val = {NSQ{3'd5}}; killer = '0;
    repeat (3) @(negedge clk);
    compare("R1 in reset");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    compare("R1 after reset");

    // flags present but no start
    step("R11 no start yet");

    // only kings, empties and code 7 present
    wipe(); put(4, 6, 1); put(11, 0, 1); put(12, 7, 0);
    start = 1; ply_idx = 5'd1;
    step("R2 R7 no eligible");

    wipe(); put(5, 4, 0); put(9, 4, 0); put(3, 2, 0); put(60, 5, 0); put(0, 6, 1);
    step("R3 queen wins");
    next = 1; step("R5 R6 tie to low index");
    next = 1; step("R6 second rook");
    next = 1; step("R6 knight");
    next = 1; step("R7 exhausted");
    next = 1; step("R6 next while exhausted ignored");
    start = 1; ply_idx = 5'd2; step("R8 fresh ply");
    next = 1; step("R6 in ply 2");
    start = 1; ply_idx = 5'd1; step("R8 return to ply 1");
    start = 1; ply_idx = 5'd2; step("R8 ply 2 restored");
    clr_ply = 1; ply_idx = 5'd1; step("R8 clear of other ply");
    start = 1; ply_idx = 5'd1; step("R9 cleared ply refilled");
    next = 1; clr_ply = 1; ply_idx = 5'd1; step("R10 next with clear");
    next = 1; start = 1; ply_idx = 5'd1; step("R10 next with start");

    wipe(); put(2, 4, 0); put(7, 4, 1); put(1, 3, 1);
    step("R4 killer beats index");
    next = 1; step("R4 R6 then plain rook");

    // random phase
    for (int n = 0; n < 6000; n++) begin
      for (int k = 0; k < NSQ; k++) begin
        found[k] = ($urandom % 4) == 0;
        piece_val[k*3 +: 3] = 3'($urandom % 8);
        killer[k] = ($urandom % 5) == 0;
      end
      start   = ($urandom % 12) == 0;
      clr_ply = ($urandom % 20) == 0;
      next    = ($urandom % 3) != 0;
      ply_idx = PLY_W'($urandom % 4);
      // hold the flags still most of the time so masks build up
      if (($urandom % 4) != 0 && n > 0) begin
        found = found_hold; piece_val = val_hold; killer = kill_hold;
      end
      found_hold = found; val_hold = piece_val; kill_hold = killer;
      step("R3 R6 R8 R9 random");
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  logic [NSQ-1:0]   found_hold;
  logic [NSQ*3-1:0] val_hold;
  logic [NSQ-1:0]   kill_hold;

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R1 watchdog: actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule